// File: doc/BRIEF.md
# Memory-Mapped Flash Read Prefetch Buffer

This block serves a single read-only bus port that looks at a serial flash through a fixed address window. It keeps one buffer of recently fetched flash bytes. A read that lands on bytes already in the buffer is answered from the buffer. A read that does not land there throws the whole buffer away. The block then asks an external flash command sequencer to refill the buffer, starting at the 32-bit word that holds the missed address.

The sequencer is reached through a request/acknowledge pair. With the request go a 4-bit sequence ID taken from configuration, the flash offset (the window base already removed) and a byte count. The count is programmed in units of 8 bytes and is capped at the buffer size. Once the sequencer has acknowledged, it streams bytes back one per valid cycle. The bus read stalls until the word it asked for has been stored.

A busy output lets command-port software wait until mapped traffic has stopped. A pair of soft-reset strobes, both asserted together, invalidates the buffer after the flash contents have been changed.

Top module: `flash_prefetch_buf`

## Requirements
- R1: A read whose 4-byte word has already been stored in a valid buffer returns the stored data with `rd_ready` high for exactly one cycle. This happens on the third rising edge after the request is first sampled, and no sequencer request is issued.
- R2: A read that is not served from the buffer raises `sq_req` with `sq_seq_id` equal to `cfg_seq_id`, and with `sq_offset` equal to `rd_addr - WIN_BASE` with bits 1:0 forced to zero. `sq_req` is held until `sq_ack` is sampled high.
- R3: `sq_len_bytes` equals `cfg_fill_units` times 8. A field value of 0 gives 8 bytes, and any product above `BUF_BYTES` is cut down to `BUF_BYTES`.
- R4: During a refill, a read of a word inside the window being fetched stalls with `rd_ready` low until that word has arrived, then returns it without a new sequencer request.
- R5: Only words that have actually been stored count as hits. A read of the word just past a completed fill is a miss.
- R6: `busy` is low after reset. It is high from the cycle after a read is accepted until its data is returned, and for as long as a refill is requested or in progress.
- R7: When `inv_bus` and `inv_flash` are both high in one cycle, the buffer becomes invalid, and the next read misses even at an address that was held before. Either strobe alone has no effect.
- R8: Stream bytes fill each word from the least significant byte upward, so the byte at offset 4k sits in bits 7:0. With `cfg_swap` high the returned word has its four bytes reversed.
- R9: After reset, `sq_req`, `rd_ready` and `busy` are low and the buffer is invalid, so the first read misses.
- R10: A read outside the window of a refill that is in progress waits until that refill finishes. It then misses and starts a new refill at its own address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_seq_id | input | 4 | Sequence ID sent with each refill request |
| cfg_fill_units | input | 8 | Refill length in 8-byte units (0 means one unit) |
| cfg_swap | input | 1 | Reverse byte order of returned words |
| inv_bus | input | 1 | Bus-side soft-reset strobe |
| inv_flash | input | 1 | Flash-side soft-reset strobe |
| rd_req | input | 1 | Read request, held until `rd_ready` |
| rd_addr | input | AW (32) | Mapped byte address of the read |
| rd_ready | output | 1 | One-cycle pulse, `rd_data` valid |
| rd_data | output | 32 | Returned word |
| busy | output | 1 | Mapped access or refill in progress |
| sq_req | output | 1 | Refill request to the sequencer |
| sq_seq_id | output | 4 | Sequence ID of the refill |
| sq_offset | output | AW (32) | Flash byte offset of the refill |
| sq_len_bytes | output | CW+2 (11) | Refill length in bytes |
| sq_ack | input | 1 | Sequencer has taken the request |
| sq_bvalid | input | 1 | Stream byte valid |
| sq_byte | input | 8 | Stream byte |

## Verification
A stale start address or word count in the buffer shows up as wrong data on the very next hit, or as a refill request that should not be there, within three cycles of the read. A fill counter that runs too far or stops too soon changes `sq_len_bytes` or the hit/miss decision at the window edge. The bench therefore reads every word of each window and the first word past it. A lost invalidate shows up as a hit, with no request, on the first read after both strobes. A broken stall shows up as a return that comes too early with wrong data.

// File: rtl/fpb_pkg.sv
package fpb_pkg;
  typedef enum logic [1:0] {FS_IDLE, FS_REQ, FS_FILL} fill_st_e;

  function automatic logic [31:0] order_word(input logic [31:0] w, input logic swap);
    return swap ? {w[7:0], w[15:8], w[23:16], w[31:24]} : w;
  endfunction
endpackage

// File: rtl/fpb_store.sv
module fpb_store #(
  parameter int DEPTH = 256,
  parameter int IW    = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [31:0]   wdata,
  input  logic [IW-1:0] raddr,
  output logic [31:0]   rdata
);
  logic [31:0] mem [DEPTH];

  // single write port, registered read: maps onto one block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/fpb_fill.sv
module fpb_fill
  import fpb_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DEPTH = 256,
  parameter int IW    = 8,
  parameter int CW    = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] start_off,
  input  logic [CW-1:0] len_words,
  input  logic [3:0]    seq_in,
  input  logic          sq_ack,
  input  logic          sq_bvalid,
  input  logic [7:0]    sq_byte,
  output logic          sq_req,
  output logic [AW-1:0] sq_off,
  output logic [CW+1:0] sq_len,
  output logic [3:0]    sq_seq,
  output logic          filling,
  output logic [CW-1:0] wr_words,
  output logic          we,
  output logic [IW-1:0] waddr,
  output logic [31:0]   wdata
);
  fill_st_e      st;
  logic [CW+1:0] bcnt;
  logic [23:0]   asm_q;

  assign filling = (st != FS_IDLE);
  // the word is written on the edge that also bumps wr_words
  assign we    = (st == FS_FILL) && sq_bvalid && (bcnt[1:0] == 2'd3);
  assign waddr = wr_words[IW-1:0];
  assign wdata = {sq_byte, asm_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= FS_IDLE;
      sq_req   <= 1'b0;
      sq_off   <= '0;
      sq_len   <= '0;
      sq_seq   <= '0;
      wr_words <= '0;
      bcnt     <= '0;
      asm_q    <= '0;
    end else begin
      case (st)
        FS_IDLE: if (start) begin
          st       <= FS_REQ;
          sq_req   <= 1'b1;
          sq_off   <= start_off;
          sq_len   <= {len_words, 2'b00};
          sq_seq   <= seq_in;
          wr_words <= '0;
          bcnt     <= '0;
        end
        FS_REQ: if (sq_ack) begin
          st     <= FS_FILL;
          sq_req <= 1'b0;
        end
        FS_FILL: if (sq_bvalid) begin
          bcnt <= bcnt + 1'b1;
          case (bcnt[1:0])
            2'd0: asm_q[7:0]   <= sq_byte;
            2'd1: asm_q[15:8]  <= sq_byte;
            2'd2: asm_q[23:16] <= sq_byte;
            default: wr_words <= wr_words + 1'b1;
          endcase
          if (bcnt == sq_len - 1'b1) st <= FS_IDLE;
        end
        default: st <= FS_IDLE;
      endcase
    end
  end

  p_req_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (sq_req && !sq_ack) |=> sq_req);

  p_len_bound_r3: assert property (@(posedge clk) disable iff (rst)
    sq_req |-> (sq_len != 0) && (sq_len <= (CW+2)'(DEPTH*4)));

  p_no_overrun_r5: assert property (@(posedge clk) disable iff (rst)
    filling |-> (wr_words <= sq_len[CW+1:2]));
endmodule

// File: rtl/flash_prefetch_buf.sv
module flash_prefetch_buf
  import fpb_pkg::*;
#(
  parameter int          AW        = 32,
  parameter logic [31:0] WIN_BASE  = 32'h6000_0000,
  parameter int          BUF_BYTES = 1024,
  localparam int         DEPTH     = BUF_BYTES / 4,
  localparam int         IW        = $clog2(DEPTH),
  localparam int         CW        = IW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [3:0]    cfg_seq_id,
  input  logic [7:0]    cfg_fill_units,
  input  logic          cfg_swap,
  input  logic          inv_bus,
  input  logic          inv_flash,
  input  logic          rd_req,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_ready,
  output logic [31:0]   rd_data,
  output logic          busy,
  output logic          sq_req,
  output logic [3:0]    sq_seq_id,
  output logic [AW-1:0] sq_offset,
  output logic [CW+1:0] sq_len_bytes,
  input  logic          sq_ack,
  input  logic          sq_bvalid,
  input  logic [7:0]    sq_byte
);
  localparam int WW = AW - 2;
  localparam int LW = (CW > 10) ? CW : 10;

  logic [AW-1:0] off;
  logic [WW-1:0] off_w, rel, start_w;
  logic [CW-1:0] tgt_w, wr_words, len_words;
  logic [LW-1:0] units2, len_clamp;
  logic          valid_q, acc_q, s_rd;
  logic          in_rng, hit, pend, eval, do_hit, do_miss, filling;
  logic          we;
  logic [IW-1:0] waddr;
  logic [31:0]   wdata, mem_q;

  assign off    = rd_addr - AW'(WIN_BASE);
  assign off_w  = off[AW-1:2];
  assign rel    = off_w - start_w;
  assign in_rng = (off_w >= start_w);
  assign hit    = valid_q && in_rng && (rel < WW'(wr_words));
  assign pend   = valid_q && in_rng && (rel < WW'(tgt_w)) && filling;
  assign eval   = acc_q && !s_rd;
  assign do_hit = eval && hit;
  assign do_miss = eval && !hit && !pend && !filling;

  // refill length in words: two per 8-byte unit, at least one unit, capped
  assign units2    = LW'({cfg_fill_units, 1'b0});
  assign len_clamp = (units2 == '0) ? LW'(2) :
                     (units2 > LW'(DEPTH)) ? LW'(DEPTH) : units2;
  assign len_words = len_clamp[CW-1:0];

  assign busy = filling | acc_q;

  fpb_fill #(.AW(AW), .DEPTH(DEPTH), .IW(IW), .CW(CW)) u_fill (
    .clk       (clk),
    .rst       (rst),
    .start     (do_miss),
    .start_off ({off_w, 2'b00}),
    .len_words (len_words),
    .seq_in    (cfg_seq_id),
    .sq_ack    (sq_ack),
    .sq_bvalid (sq_bvalid),
    .sq_byte   (sq_byte),
    .sq_req    (sq_req),
    .sq_off    (sq_offset),
    .sq_len    (sq_len_bytes),
    .sq_seq    (sq_seq_id),
    .filling   (filling),
    .wr_words  (wr_words),
    .we        (we),
    .waddr     (waddr),
    .wdata     (wdata)
  );

  fpb_store #(.DEPTH(DEPTH), .IW(IW)) u_store (
    .clk   (clk),
    .we    (we),
    .waddr (waddr),
    .wdata (wdata),
    .raddr (rel[IW-1:0]),
    .rdata (mem_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q  <= 1'b0;
      acc_q    <= 1'b0;
      s_rd     <= 1'b0;
      rd_ready <= 1'b0;
      rd_data  <= '0;
      start_w  <= '0;
      tgt_w    <= '0;
    end else begin
      rd_ready <= 1'b0;
      if (rd_req && !acc_q && !rd_ready) acc_q <= 1'b1;
      if (inv_bus && inv_flash) valid_q <= 1'b0;
      if (do_miss) begin
        valid_q <= 1'b1;
        start_w <= off_w;
        tgt_w   <= len_words;
      end
      s_rd <= do_hit;
      if (s_rd) begin
        rd_data  <= order_word(mem_q, cfg_swap);
        rd_ready <= 1'b1;
        acc_q    <= 1'b0;
      end
    end
  end

  p_ready_pulse_r1: assert property (@(posedge clk) disable iff (rst)
    rd_ready |=> !rd_ready);

  p_ready_after_read_r4: assert property (@(posedge clk) disable iff (rst)
    rd_ready |-> $past(s_rd));

  p_busy_fill_r6: assert property (@(posedge clk) disable iff (rst)
    (filling || sq_req) |-> busy);

  p_req_from_idle_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(sq_req) |-> $past(!filling));
endmodule

// File: tb/flash_prefetch_buf_bench.sv
module flash_prefetch_buf_bench;
  localparam logic [31:0] BASE = 32'h6000_0000;
  localparam int BUFB = 1024;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  cfg_seq_id = 4'hA;
  logic [7:0]  cfg_fill_units = 8'd4;
  logic        cfg_swap = 1'b0;
  logic        inv_bus = 1'b0, inv_flash = 1'b0;
  logic        rd_req = 1'b0;
  logic [31:0] rd_addr = '0;
  logic        rd_ready, busy, sq_req;
  logic [31:0] rd_data, sq_offset;
  logic [3:0]  sq_seq_id;
  logic [10:0] sq_len_bytes;
  logic        sq_ack = 1'b0, sq_bvalid = 1'b0;
  logic [7:0]  sq_byte = '0;

  int n_chk = 0, n_bad = 0;
  int req_cnt = 0;
  logic [31:0] last_off;
  int last_len;
  logic [3:0] last_seq;

  always #2.5 clk = ~clk;

  flash_prefetch_buf u_flash_prefetch_buf (
    .clk(clk), .rst(rst), .cfg_seq_id(cfg_seq_id), .cfg_fill_units(cfg_fill_units),
    .cfg_swap(cfg_swap), .inv_bus(inv_bus), .inv_flash(inv_flash),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_ready(rd_ready), .rd_data(rd_data),
    .busy(busy), .sq_req(sq_req), .sq_seq_id(sq_seq_id), .sq_offset(sq_offset),
    .sq_len_bytes(sq_len_bytes), .sq_ack(sq_ack), .sq_bvalid(sq_bvalid), .sq_byte(sq_byte)
  );

  function automatic logic [7:0] fb(input logic [31:0] o);
    return 8'((o * 37) ^ (o >> 8) ^ 32'h5A);
  endfunction

  function automatic logic [31:0] ew(input logic [31:0] o, input logic sw);
    logic [31:0] w;
    w = {fb(o + 3), fb(o + 2), fb(o + 1), fb(o)};
    return sw ? {w[7:0], w[15:8], w[23:16], w[31:24]} : w;
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // flash sequencer model: acks after two cycles, streams with a gap every 7th byte
  initial begin
    forever begin
      @(negedge clk);
      if (sq_req) begin
        req_cnt++;
        last_off = sq_offset;
        last_len = int'(sq_len_bytes);
        last_seq = sq_seq_id;
        repeat (2) @(negedge clk);
        sq_ack = 1'b1;
        @(negedge clk);
        sq_ack = 1'b0;
        for (int i = 0; i < last_len; i++) begin
          if (i % 7 == 6) begin
            sq_bvalid = 1'b0;
            @(negedge clk);
          end
          sq_bvalid = 1'b1;
          sq_byte = fb(last_off + 32'(i));
          @(negedge clk);
        end
        sq_bvalid = 1'b0;
      end
    end
  end

  bit busy_gap;
  task automatic do_read(input logic [31:0] off, output logic [31:0] d, output int lat);
    @(negedge clk);
    rd_req = 1'b1;
    rd_addr = BASE + off;
    lat = 0;
    busy_gap = 0;
    while (1) begin
      @(negedge clk);
      lat++;
      if (rd_ready) break;
      if (!busy) busy_gap = 1;
      if (lat > 20000) break;
    end
    d = rd_data;
    rd_req = 1'b0;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 20000; k++) begin
      @(negedge clk);
      if (!busy && !sq_req) break;
    end
  endtask

  task automatic pulse_inv(input logic b, input logic f);
    @(negedge clk);
    inv_bus = b; inv_flash = f;
    @(negedge clk);
    inv_bus = 0; inv_flash = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int lat, c0;
    logic [7:0] units [5];
    int explen [5];
    units = '{8'd0, 8'd1, 8'd3, 8'd128, 8'd200};
    explen = '{8, 8, 24, 1024, 1024};

    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    chk(!busy && !sq_req && !rd_ready, "R9 reset outputs", {busy, sq_req, rd_ready}, 0);

    // R2 R9 first read misses; R3 length; R6 busy during wait; R4 stall
    do_read(32'h42, d, lat);
    chk(req_cnt == 1, "R9 first read misses", req_cnt, 1);
    chk(last_off == 32'h40, "R2 offset", last_off, 32'h40);
    chk(last_seq == 4'hA, "R2 seq id", last_seq, 4'hA);
    chk(last_len == 32, "R3 length 4 units", last_len, 32);
    chk(d == ew(32'h40, 0), "R4 stalled data", d, ew(32'h40, 0));
    chk(lat > 3, "R4 stall latency", lat, 4);
    chk(!busy_gap, "R6 busy during miss", busy_gap, 0);
    wait_idle();
    chk(!busy, "R6 busy idle", busy, 0);

    // R1 R8 hits across window
    c0 = req_cnt;
    for (int w = 0; w < 8; w++) begin
      do_read(32'h40 + 32'(w * 4), d, lat);
      chk(d == ew(32'h40 + 32'(w * 4), 0), "R8 hit data order", d, ew(32'h40 + 32'(w * 4), 0));
      chk(lat == 3, "R1 hit latency", lat, 3);
    end
    chk(req_cnt == c0, "R1 no request on hits", req_cnt, c0);

    // R5 word past window misses
    do_read(32'h60, d, lat);
    chk(req_cnt == c0 + 1 && last_off == 32'h60, "R5 past window misses", last_off, 32'h60);
    wait_idle();

    // R8 swapped
    cfg_swap = 1'b1;
    do_read(32'h64, d, lat);
    chk(d == ew(32'h64, 1), "R8 swapped word", d, ew(32'h64, 1));
    cfg_swap = 1'b0;

    // R7 single strobes ignored, both invalidate
    c0 = req_cnt;
    pulse_inv(1, 0);
    do_read(32'h60, d, lat);
    chk(req_cnt == c0 && lat == 3, "R7 inv_bus alone ignored", req_cnt, c0);
    pulse_inv(0, 1);
    do_read(32'h60, d, lat);
    chk(req_cnt == c0 && lat == 3, "R7 inv_flash alone ignored", req_cnt, c0);
    pulse_inv(1, 1);
    do_read(32'h60, d, lat);
    chk(req_cnt == c0 + 1, "R7 both strobes invalidate", req_cnt, c0 + 1);
    chk(d == ew(32'h60, 0), "R7 data after invalidate", d, ew(32'h60, 0));
    wait_idle();

    // R3 R5 length sweep with full-window hit sweep
    for (int u = 0; u < 5; u++) begin
      logic [31:0] b;
      b = 32'h1000 * 32'(u + 1);
      cfg_fill_units = units[u];
      cfg_seq_id = 4'(u + 3);
      do_read(b, d, lat);
      chk(last_len == explen[u], "R3 fill length", last_len, explen[u]);
      chk(last_seq == 4'(u + 3), "R2 seq id sweep", last_seq, 4'(u + 3));
      wait_idle();
      c0 = req_cnt;
      for (int w = 0; w < explen[u] / 4; w++) begin
        do_read(b + 32'(w * 4), d, lat);
        chk(d == ew(b + 32'(w * 4), 0), "R1 sweep hit data", d, ew(b + 32'(w * 4), 0));
      end
      chk(req_cnt == c0, "R5 whole window hits", req_cnt, c0);
      do_read(b + 32'(explen[u]), d, lat);
      chk(req_cnt == c0 + 1, "R5 first word past window", req_cnt, c0 + 1);
      wait_idle();
    end

    // R4 read ahead inside a running fill
    cfg_fill_units = 8'd128;
    do_read(32'h8000, d, lat);
    c0 = req_cnt;
    do_read(32'h8200, d, lat);
    chk(req_cnt == c0 && d == ew(32'h8200, 0), "R4 in-window stall", d, ew(32'h8200, 0));
    wait_idle();

    // R10 out-of-window read during fill
    do_read(32'h9000, d, lat);
    c0 = req_cnt;
    do_read(32'hA004, d, lat);
    chk(req_cnt == c0 + 1 && last_off == 32'hA004, "R10 waits then misses", last_off, 32'hA004);
    chk(d == ew(32'hA004, 0), "R10 data", d, ew(32'hA004, 0));
    chk(!busy_gap, "R6 busy while waiting", busy_gap, 0);
    wait_idle();

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule